// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits between an 8-bit CPU's 16-bit address bus and four storage regions of a game-console memory map: work RAM, the video-unit register window, the audio/IO register window and the cartridge space. For every access it raises one select line, works out the offset to present to that region and forwards the write data and write strobe. It also steers the read data of the selected region back to the CPU in the same cycle.

The block is purely combinational. Region boundaries are fixed. Mirrored regions are folded by masking low address bits. The 2 KiB work RAM therefore repeats four times over its 8 KiB span, and the 8-byte video window repeats across its 8 KiB span. The two upper regions receive their address with the region base removed, so their storage starts at offset zero. Reads and writes follow identical decode rules.

The CPU side uses plain strobes rather than a valid/ready pair. A strobe held high is an access in that cycle, and the block never pushes back.

Top module: `bus_decoder`

## Requirements
- R1: Addresses 0x0000..0x1FFF raise `rgn_sel[0]` (work RAM), and `rgn_addr` equals the address modulo 0x800.
- R2: Addresses 0x2000..0x3FFF raise `rgn_sel[1]` (video registers), and `rgn_addr` equals the address modulo 8.
- R3: Addresses 0x4000..0x401F raise `rgn_sel[2]` (audio/IO registers), and `rgn_addr` equals the address minus 0x4000.
- R4: Addresses 0x4020..0xFFFF raise `rgn_sel[3]` (cartridge), and `rgn_addr` equals the address minus 0x4020.
- R5: When `cpu_rd` or `cpu_wr` is high, exactly one bit of `rgn_sel` is high. When both strobes are low, `rgn_sel` is all zero and `rgn_addr` is zero.
- R6: `cpu_rdata` equals slice i of `rgn_rdata` (bits i*DATA_W upward, with region i numbered as in R1..R4) when `rgn_sel[i]` is high, in the same cycle. It is zero when no select is high.
- R7: `rgn_wdata` always equals `cpu_wdata`, and `rgn_we` always equals `cpu_wr`.
- R8: Writes and reads share one decode, so a byte written through any mirror alias of a location reads back through every other alias of it.
- R9: The region edges decode exactly: 0x1FFF, 0x2000, 0x3FFF, 0x4000, 0x401F, 0x4020 and 0xFFFF each fall in the region named in R1..R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| rgn_sel | output | 4 | One-hot region select (0 RAM, 1 video, 2 audio/IO, 3 cartridge) |
| rgn_addr | output | 16 | Offset inside the selected region |
| rgn_wdata | output | DATA_W | Write data forwarded to the regions |
| rgn_we | output | 1 | Write strobe forwarded to the regions |
| rgn_rdata | input | 4*DATA_W | Read data of all regions, region 0 in the low slice |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |

## Verification
The bench attacks the seven region edges, where an off-by-one range compare would hand the edge address to a neighbouring region. It also attacks the mirror aliases. A write to 0x0805 must read back at 0x0005, 0x1005 and 0x1805, and a write to 0x2009 must read back at 0x3FF1. A wrong fold mask would store the byte at one offset and fetch it from another. The cartridge and audio/IO offsets are checked against base-subtracted values, which catches a design that forwards the raw address. Idle cycles catch any select or read data that leaks out when no strobe is active.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  localparam int ADDR_W  = 16;
  localparam int NUM_RGN = 4;

  typedef enum logic [1:0] {
    RGN_WRAM = 2'd0,
    RGN_VREG = 2'd1,
    RGN_AIO  = 2'd2,
    RGN_CART = 2'd3
  } rgn_e;

  // Lowest address of each region.
  function automatic logic [ADDR_W-1:0] rgn_lo(input int idx);
    case (idx)
      0:       rgn_lo = 16'h0000;
      1:       rgn_lo = 16'h2000;
      2:       rgn_lo = 16'h4000;
      default: rgn_lo = 16'h4020;
    endcase
  endfunction

  // Highest address of each region.
  function automatic logic [ADDR_W-1:0] rgn_hi(input int idx);
    case (idx)
      0:       rgn_hi = 16'h1FFF;
      1:       rgn_hi = 16'h3FFF;
      2:       rgn_hi = 16'h401F;
      default: rgn_hi = 16'hFFFF;
    endcase
  endfunction

  // Mirrored regions fold by masking; the others subtract their base.
  function automatic bit rgn_folds(input int idx);
    rgn_folds = (idx == 0) || (idx == 1);
  endfunction

  function automatic logic [ADDR_W-1:0] rgn_mask(input int idx);
    case (idx)
      0:       rgn_mask = 16'h07FF;
      1:       rgn_mask = 16'h0007;
      default: rgn_mask = 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/busdec_rgn_match.sv
module busdec_rgn_match
  import busdec_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] local_o
);
  localparam logic [ADDR_W-1:0] LO   = rgn_lo(IDX);
  localparam logic [ADDR_W-1:0] SPAN = rgn_hi(IDX) - rgn_lo(IDX);

  logic [ADDR_W-1:0] offset;

  // A wrapped subtraction turns the two-sided range test into one compare.
  always_comb begin
    offset = addr_i - LO;
    hit_o  = (offset <= SPAN);
  end

  generate
    if (rgn_folds(IDX)) begin : g_fold
      localparam logic [ADDR_W-1:0] MSK = rgn_mask(IDX);
      assign local_o = addr_i & MSK;
    end else begin : g_base
      assign local_o = offset;
    end
  endgenerate
endmodule

// File: rtl/busdec_onehot_mux.sv
module busdec_onehot_mux #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] din_i,
  output logic [W-1:0]   dout_o
);
  always_comb begin
    dout_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) dout_o = dout_o | din_i[i*W +: W];
    end
  end
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder
  import busdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  input  logic                      cpu_rd,
  input  logic                      cpu_wr,
  output logic [NUM_RGN-1:0]        rgn_sel,
  output logic [ADDR_W-1:0]         rgn_addr,
  output logic [DATA_W-1:0]         rgn_wdata,
  output logic                      rgn_we,
  input  logic [NUM_RGN*DATA_W-1:0] rgn_rdata,
  output logic [DATA_W-1:0]         cpu_rdata
);
  localparam int LOC_FLAT_W = NUM_RGN * ADDR_W;

  logic [NUM_RGN-1:0]    hit;
  logic [LOC_FLAT_W-1:0] loc_flat;
  logic                  active;

  generate
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      busdec_rgn_match #(.IDX(g)) u_match (
        .addr_i (cpu_addr),
        .hit_o  (hit[g]),
        .local_o(loc_flat[g*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  assign active  = cpu_rd | cpu_wr;
  assign rgn_sel = hit & {NUM_RGN{active}};

  busdec_onehot_mux #(.N(NUM_RGN), .W(ADDR_W)) u_addr_mux (
    .sel_i (rgn_sel),
    .din_i (loc_flat),
    .dout_o(rgn_addr)
  );

  busdec_onehot_mux #(.N(NUM_RGN), .W(DATA_W)) u_rdata_mux (
    .sel_i (rgn_sel),
    .din_i (rgn_rdata),
    .dout_o(cpu_rdata)
  );

  assign rgn_wdata = cpu_wdata;
  assign rgn_we    = cpu_wr;
endmodule

// File: rtl/bus_decoder_chk.sv
module bus_decoder_chk
  import busdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [ADDR_W-1:0]         cpu_addr,
  input logic [DATA_W-1:0]         cpu_wdata,
  input logic                      cpu_rd,
  input logic                      cpu_wr,
  input logic [NUM_RGN-1:0]        rgn_sel,
  input logic [ADDR_W-1:0]         rgn_addr,
  input logic [DATA_W-1:0]         rgn_wdata,
  input logic                      rgn_we,
  input logic [NUM_RGN*DATA_W-1:0] rgn_rdata,
  input logic [DATA_W-1:0]         cpu_rdata
);
  always_comb begin
    // R5
    sel_onehot_chk: assert ((cpu_rd || cpu_wr) ? ($countones(rgn_sel) == 1) : (rgn_sel == '0));
    // R1
    wram_fold_chk: assert (!rgn_sel[0] || (cpu_addr <= 16'h1FFF && rgn_addr == (cpu_addr & 16'h07FF)));
    // R2
    vreg_fold_chk: assert (!rgn_sel[1] || (cpu_addr[15:13] == 3'b001 && rgn_addr[15:3] == '0 && rgn_addr[2:0] == cpu_addr[2:0]));
    // R3
    aio_base_chk: assert (!rgn_sel[2] || (rgn_addr < 16'd32 && (rgn_addr + 16'h4000) == cpu_addr));
    // R4
    cart_base_chk: assert (!rgn_sel[3] || (cpu_addr >= 16'h4020 && (rgn_addr + 16'h4020) == cpu_addr));
    // R6
    rdata_idle_chk: assert (rgn_sel != '0 || cpu_rdata == '0);
    // R7
    wr_pass_chk: assert (rgn_wdata == cpu_wdata && rgn_we == cpu_wr);
  end

  generate
    for (genvar i = 0; i < NUM_RGN; i++) begin : g_rd
      always_comb begin
        // R6
        rdata_route_chk: assert (!rgn_sel[i] || cpu_rdata == rgn_rdata[i*DATA_W +: DATA_W]);
      end
    end
  endgenerate
endmodule

bind bus_decoder bus_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .cpu_rd   (cpu_rd),
  .cpu_wr   (cpu_wr),
  .rgn_sel  (rgn_sel),
  .rgn_addr (rgn_addr),
  .rgn_wdata(rgn_wdata),
  .rgn_we   (rgn_we),
  .rgn_rdata(rgn_rdata),
  .cpu_rdata(cpu_rdata)
);

// File: tb/sim_bus_decoder.sv
module sim_bus_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [3:0]  rgn_sel;
  logic [15:0] rgn_addr;
  logic [7:0]  rgn_wdata, cpu_rdata;
  logic        rgn_we;
  logic [31:0] rgn_rdata;

  bus_decoder u0 (
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .rgn_sel(rgn_sel), .rgn_addr(rgn_addr), .rgn_wdata(rgn_wdata), .rgn_we(rgn_we),
    .rgn_rdata(rgn_rdata), .cpu_rdata(cpu_rdata)
  );

  // Behavioural region storage (cartridge kept to 256 bytes, tests avoid its aliasing)
  logic [7:0] m_ram [2048];
  logic [7:0] m_vid [8];
  logic [7:0] m_aio [32];
  logic [7:0] m_cart[256];

  initial begin
    for (int i = 0; i < 2048; i++) m_ram[i] = '0;
    for (int i = 0; i < 8; i++)    m_vid[i] = '0;
    for (int i = 0; i < 32; i++)   m_aio[i] = '0;
    for (int i = 0; i < 256; i++)  m_cart[i] = '0;
  end

  assign rgn_rdata = {m_cart[rgn_addr[7:0]], m_aio[rgn_addr[4:0]],
                      m_vid[rgn_addr[2:0]], m_ram[rgn_addr[10:0]]};

  always @(posedge clk) begin
    if (rgn_we) begin
      if (rgn_sel[0]) m_ram[rgn_addr[10:0]] <= rgn_wdata;
      if (rgn_sel[1]) m_vid[rgn_addr[2:0]]  <= rgn_wdata;
      if (rgn_sel[2]) m_aio[rgn_addr[4:0]]  <= rgn_wdata;
      if (rgn_sel[3]) m_cart[rgn_addr[7:0]] <= rgn_wdata;
    end
  end

  typedef struct {
    logic [3:0]  sel;
    logic [15:0] loc;
    logic [7:0]  rd;
    bit          chk_rd;
    logic [7:0]  wd;
    bit          chk_wd;
    string       req;
  } item_t;

  item_t      q[$];
  logic [7:0] ref_mem[int];
  int         total = 0, bad = 0;
  bit         done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected map derived from R1..R4
  task automatic exp_map(input logic [15:0] a, output int rgn, output logic [15:0] loc);
    if (a <= 16'h1FFF)      begin rgn = 0; loc = a % 16'h0800; end
    else if (a <= 16'h3FFF) begin rgn = 1; loc = a % 16'd8; end
    else if (a <= 16'h401F) begin rgn = 2; loc = a - 16'h4000; end
    else                    begin rgn = 3; loc = a - 16'h4020; end
  endtask

  task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] d,
                        input string req);
    item_t it;
    int rgn;
    logic [15:0] loc;
    int key;
    exp_map(a, rgn, loc);
    key = rgn * 65536 + int'(loc);
    @(negedge clk);
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = d;
    it.sel = 4'b0001 << rgn;
    it.loc = loc;
    it.chk_rd = !wr;
    it.rd = ref_mem.exists(key) ? ref_mem[key] : 8'h00;
    it.chk_wd = wr;
    it.wd = d;
    it.req = req;
    if (wr) ref_mem[key] = d;
    q.push_back(it);
  endtask

  task automatic idle(input string req);
    item_t it;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; cpu_addr = 16'h1234; cpu_wdata = 8'h5E;
    it.sel = '0; it.loc = '0; it.rd = '0; it.chk_rd = 1;
    it.wd = 8'h5E; it.chk_wd = 1; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(rgn_sel == it.sel, it.req, "sel", rgn_sel, it.sel);
        check(rgn_addr == it.loc, it.req, "addr", rgn_addr, it.loc);
        if (it.chk_rd) check(cpu_rdata == it.rd, it.req, "rdata", cpu_rdata, it.rd);
        if (it.chk_wd) begin
          check(rgn_wdata == it.wd, it.req, "wdata", rgn_wdata, it.wd);
          check(rgn_we == cpu_wr, it.req, "we", rgn_we, cpu_wr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset/idle state: R5, R6
    idle("R5_idle");
    // R1 and R8 mirror aliasing in work RAM
    access(16'h0805, 1, 8'hA5, "R1_wr");
    access(16'h0005, 0, 8'h00, "R8_ram_alias0");
    access(16'h1005, 0, 8'h00, "R8_ram_alias1");
    access(16'h1805, 0, 8'h00, "R8_ram_alias2");
    access(16'h0006, 0, 8'h00, "R1_neighbour");
    // R2 and R8 video window folding
    access(16'h2009, 1, 8'h3C, "R2_wr");
    access(16'h3FF1, 0, 8'h00, "R8_vid_alias");
    access(16'h2001, 0, 8'h00, "R2_rd");
    // R3 audio/IO base removal
    access(16'h4011, 1, 8'h77, "R3_wr");
    access(16'h4011, 0, 8'h00, "R3_rd");
    // R4 cartridge base removal
    access(16'h8000, 1, 8'h5A, "R4_wr");
    access(16'h8000, 0, 8'h00, "R4_rd");
    access(16'h4025, 1, 8'h12, "R4_wr_low");
    access(16'h4025, 0, 8'h00, "R4_rd_low");
    // R9 region edges
    access(16'h1FFF, 1, 8'h99, "R9_ram_top");
    access(16'h07FF, 0, 8'h00, "R9_ram_top_alias");
    access(16'h2000, 0, 8'h00, "R9_vid_base");
    access(16'h3FFF, 0, 8'h00, "R9_vid_top");
    access(16'h4000, 0, 8'h00, "R9_aio_base");
    access(16'h401F, 0, 8'h00, "R9_aio_top");
    access(16'h4020, 0, 8'h00, "R9_cart_base");
    access(16'hFFFF, 0, 8'h00, "R9_cart_top");
    // R6 routing between distinct regions back to back
    access(16'h1805, 0, 8'h00, "R6_ram");
    access(16'h2801, 0, 8'h00, "R6_vid");
    idle("R6_idle");
    // R7 write pass-through with distinct data
    access(16'h4003, 1, 8'hC3, "R7_wr");
    access(16'h4003, 0, 8'h00, "R7_rd");
    idle("R5_idle_end");
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule